// File: doc/BRIEF.md
# Serial Flash Clock and Select Sequencer

This block produces the serial clock and the chip-select lines for a single serial flash transaction, running entirely from a reference clock. A transaction starts when a request is accepted. The block then lowers chip select and waits a programmed setup time. It issues eight clock periods per byte, waits a programmed hold time, raises chip select and pulses a completion strobe. Shift and sample strobes mark every clock edge on which a separate data path must launch or capture a bit. The data path and any register access stay outside this block.

The clock rate comes from a divider field. Clock polarity and clock phase are selected independently. The chip-select bus works in one of two modes: a one-hot active-low mode for directly wired devices, or a raw code for an external decoder. Four delay counts, expressed in reference cycles, shape the select timing. Two of them set the setup and hold around the clock burst. The other two set the minimum time chip select stays high between transactions: one applies when the same device is selected again, the other when a different device is selected. All settings are captured when a request is accepted, so changing them during a transaction has no effect.

Top module: `sclk_cs_sequencer`

## Requirements
- R1: With divider field N, every SCLK half period lasts exactly N+1 reference cycles, which gives a period of 2*(N+1).
- R2: While chip select is high, SCLK rests at the polarity level `cpol_i` that was captured while the block was idle. This includes the reset state, where the level is 0.
- R3: In phase mode 0, `sample_o` pulses on each leading SCLK edge (odd edges), and `shift_o` pulses on each trailing edge except the final one. In phase mode 1, `shift_o` pulses on each leading edge and `sample_o` on each trailing edge. The two strobes never coincide, and each one pulses in the same cycle as its SCLK transition.
- R4: A transaction with `nbytes_i` = B produces exactly 16*(B+1) SCLK transitions, that is, 8*(B+1) clock periods.
- R5: With `decode_i` = 0, the selected device drives `cs_no` = ~(1 << `cs_sel_i[1:0]`), for example 4'b1101 for index 1. Bits 3:2 of `cs_sel_i` are ignored.
- R6: With `decode_i` = 1, `cs_no` carries `cs_sel_i` unchanged for the whole transaction.
- R7: The first SCLK transition occurs max(`delay_i[7:0]`,1) + N + 1 cycles after chip select falls.
- R8: Chip select rises max(`delay_i[15:8]`,1) cycles after the last SCLK transition.
- R9: A new transaction on the same chip-select pattern does not lower chip select until it has been high for `delay_i[31:24]` cycles. A request presented in the cycle after `done_o` gives a high time of exactly max(`delay_i[31:24]`,2).
- R10: When the pattern differs from that of the previous transaction, `delay_i[23:16]` governs the high time instead, under the same rule as R9.
- R11: `done_o` pulses for one cycle in the cycle chip select rises. `idle_o` is low from the cycle after the request is accepted until that cycle, and high otherwise.
- R12: While `enable_i` is low, requests are ignored: chip select stays high and `idle_o` stays high.
- R13: Divider, phase, select and delay inputs are captured at acceptance. Changing them during a transaction does not alter its timing or pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Allows new transactions to be accepted |
| baud_i | input | DIV_W | Divider field N |
| cpol_i | input | 1 | Clock polarity |
| cpha_i | input | 1 | Clock phase |
| decode_i | input | 1 | 1: raw select code, 0: one-hot active low |
| cs_sel_i | input | CS_W | Select code or device index |
| delay_i | input | 4*DLY_W | Setup, hold, device-switch gap, same-device gap (low to high byte) |
| req_i | input | 1 | Transaction request, sampled while idle |
| nbytes_i | input | CNT_W | Byte count minus one |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | CS_W | Chip-select bus, active low |
| shift_o | output | 1 | Launch-next-bit strobe |
| sample_o | output | 1 | Capture-bit strobe |
| done_o | output | 1 | One-cycle completion pulse |
| idle_o | output | 1 | Sequencer idle |

## Verification
The bench builds the block with its default parameters: a 4-bit divider, 8-bit delays, a 4-bit byte count and four select lines. With these values it can drive the divider and delay boundaries (0 and 1 rounding up to one cycle) and multi-byte bursts in a few hundred cycles. Back-to-back requests issued in the cycle after completion make the exact select-high time observable. That exposes both gap rules and the two-cycle floor, and switching the index between transactions exercises the device-change path.

// File: rtl/sclk_cs_pkg.sv
`timescale 1ns/1ps
package sclk_cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_SETUP = 3'd2,
    ST_XFER  = 3'd3,
    ST_HOLD  = 3'd4
  } seq_st_e;
endpackage

// File: rtl/cs_pattern.sv
`timescale 1ns/1ps
module cs_pattern #(
  parameter int CS_W = 4
) (
  input  logic            decode_i,
  input  logic [CS_W-1:0] sel_i,
  output logic [CS_W-1:0] pat_o
);
  localparam int IDX_W = (CS_W > 1) ? $clog2(CS_W) : 1;

  logic [IDX_W-1:0] idx;
  assign idx = sel_i[IDX_W-1:0];

  for (genvar k = 0; k < CS_W; k++) begin : g_bit
    assign pat_o[k] = decode_i ? sel_i[k] : (idx != IDX_W'(k));
  end
endmodule

// File: rtl/gap_timer.sv
`timescale 1ns/1ps
module gap_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_act_i,
  input  logic [DLY_W-1:0] need_i,
  output logic             ready_o
);
  logic [DLY_W-1:0] hi_q;
  logic [DLY_W:0]   hi_p1;

  assign hi_p1   = (DLY_W+1)'(hi_q) + (DLY_W+1)'(1);
  assign ready_o = hi_p1 >= (DLY_W+1)'(need_i);

  // starts saturated so the first select after reset is not held off
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        hi_q <= '1;
    else if (cs_act_i)  hi_q <= '0;
    else if (hi_q != '1) hi_q <= hi_q + 1'b1;
  end

  p_gap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_act_i) |-> $past(ready_o));
endmodule

// File: rtl/sclk_edge_gen.sv
`timescale 1ns/1ps
module sclk_edge_gen #(
  parameter int DIV_W = 4,
  parameter int EC_W  = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic [DIV_W-1:0] half_i,
  input  logic [EC_W-1:0]  nedge_i,
  output logic             sclk_o,
  output logic             shift_o,
  output logic             sample_o,
  output logic             last_o
);
  logic [DIV_W-1:0] hc_q;
  logic [EC_W-1:0]  ec_q;
  logic             ph_q, shift_q, sample_q;
  logic             tog, lead;

  assign tog    = run_i && (hc_q == half_i);
  assign lead   = ~ph_q;
  assign last_o = tog && (ec_q == nedge_i - EC_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hc_q <= '0; ec_q <= '0; ph_q <= 1'b0;
      shift_q <= 1'b0; sample_q <= 1'b0;
    end else if (!run_i) begin
      hc_q <= '0; ec_q <= '0; ph_q <= 1'b0;
      shift_q <= 1'b0; sample_q <= 1'b0;
    end else if (tog) begin
      hc_q     <= '0;
      ec_q     <= ec_q + 1'b1;
      ph_q     <= ~ph_q;
      sample_q <= lead ^ cpha_i;
      // mode 0 presents the first bit at select, so no shift after the final edge
      shift_q  <= cpha_i ? lead : (~lead && !last_o);
    end else begin
      hc_q     <= hc_q + 1'b1;
      shift_q  <= 1'b0;
      sample_q <= 1'b0;
    end
  end

  assign sclk_o   = cpol_i ^ ph_q;
  assign shift_o  = shift_q;
  assign sample_o = sample_q;

  p_strobe_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shift_q && sample_q));
endmodule

// File: rtl/sclk_cs_sequencer.sv
`timescale 1ns/1ps
module sclk_cs_sequencer
  import sclk_cs_pkg::*;
#(
  parameter int DIV_W = 4,
  parameter int DLY_W = 8,
  parameter int CNT_W = 4,
  parameter int CS_W  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               enable_i,
  input  logic [DIV_W-1:0]   baud_i,
  input  logic               cpol_i,
  input  logic               cpha_i,
  input  logic               decode_i,
  input  logic [CS_W-1:0]    cs_sel_i,
  input  logic [4*DLY_W-1:0] delay_i,
  input  logic               req_i,
  input  logic [CNT_W-1:0]   nbytes_i,
  output logic               sclk_o,
  output logic [CS_W-1:0]    cs_no,
  output logic               shift_o,
  output logic               sample_o,
  output logic               done_o,
  output logic               idle_o
);
  localparam int EC_W = CNT_W + 5;

  seq_st_e            state_q;
  logic [DIV_W-1:0]   baud_q;
  logic               cpol_q, cpha_q, dec_q;
  logic [CS_W-1:0]    pat_d, pat_q, last_pat_q;
  logic [4*DLY_W-1:0] dly_q;
  logic [CNT_W-1:0]   nb_q;
  logic [DLY_W-1:0]   dcnt_q;
  logic               done_q;

  logic [DLY_W-1:0]   d_slch, d_chsh, d_sd2d, d_shsl, need;
  logic [DLY_W:0]     dcnt_p1;
  logic               setup_ok, hold_ok, ready, last_edge, cs_on;
  logic [EC_W-1:0]    nedge;

  assign d_slch = dly_q[DLY_W-1:0];
  assign d_chsh = dly_q[2*DLY_W-1:DLY_W];
  assign d_sd2d = dly_q[3*DLY_W-1:2*DLY_W];
  assign d_shsl = dly_q[4*DLY_W-1:3*DLY_W];

  assign dcnt_p1  = (DLY_W+1)'(dcnt_q) + (DLY_W+1)'(1);
  assign setup_ok = dcnt_p1 >= (DLY_W+1)'(d_slch);
  assign hold_ok  = dcnt_p1 >= (DLY_W+1)'(d_chsh);
  assign need     = (pat_q == last_pat_q) ? d_shsl : d_sd2d;
  assign nedge    = (EC_W'(nb_q) + EC_W'(1)) << 4;
  assign cs_on    = (state_q == ST_SETUP) || (state_q == ST_XFER) || (state_q == ST_HOLD);

  cs_pattern #(.CS_W(CS_W)) u_pat (
    .decode_i (decode_i),
    .sel_i    (cs_sel_i),
    .pat_o    (pat_d)
  );

  gap_timer #(.DLY_W(DLY_W)) u_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_act_i (cs_on),
    .need_i   (need),
    .ready_o  (ready)
  );

  sclk_edge_gen #(.DIV_W(DIV_W), .EC_W(EC_W)) u_edge (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (state_q == ST_XFER),
    .cpol_i   (cpol_q),
    .cpha_i   (cpha_q),
    .half_i   (baud_q),
    .nedge_i  (nedge),
    .sclk_o   (sclk_o),
    .shift_o  (shift_o),
    .sample_o (sample_o),
    .last_o   (last_edge)
  );

  // settings follow the inputs while idle and freeze once a request is taken
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      baud_q <= '0; cpol_q <= 1'b0; cpha_q <= 1'b0; dec_q <= 1'b0;
      pat_q  <= '1; dly_q <= '0; nb_q <= '0;
    end else if (state_q == ST_IDLE) begin
      baud_q <= baud_i; cpol_q <= cpol_i; cpha_q <= cpha_i; dec_q <= decode_i;
      pat_q  <= pat_d;  dly_q  <= delay_i; nb_q <= nbytes_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      dcnt_q     <= '0;
      done_q     <= 1'b0;
      last_pat_q <= '1;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE:  if (enable_i && req_i) state_q <= ST_WAIT;
        ST_WAIT:  if (ready) begin state_q <= ST_SETUP; dcnt_q <= '0; end
        ST_SETUP: if (setup_ok) state_q <= ST_XFER;
                  else dcnt_q <= dcnt_q + 1'b1;
        ST_XFER:  if (last_edge) begin state_q <= ST_HOLD; dcnt_q <= '0; end
        ST_HOLD:  if (hold_ok) begin
                    state_q    <= ST_IDLE;
                    done_q     <= 1'b1;
                    last_pat_q <= pat_q;
                  end else dcnt_q <= dcnt_q + 1'b1;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no  = cs_on ? pat_q : '1;
  assign done_o = done_q;
  assign idle_o = (state_q == ST_IDLE);

  p_sclk_rest_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_on |-> (sclk_o == cpol_q));
  p_cs_stable_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_on && $past(cs_on)) |-> $stable(cs_no));
  p_done_rise_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!cs_on && $past(cs_on)));
  p_onehot_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_on && !dec_q) |-> ($countones(cs_no) == CS_W-1));
  p_strobe_cs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_o || sample_o) |-> cs_on);
  p_enable_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && !enable_i) |=> idle_o);
endmodule

// File: tb/sclk_cs_sequencer_tb_top.sv
`timescale 1ns/1ps
module sclk_cs_sequencer_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b1;
  logic [3:0]  baud_i = '0;
  logic        cpol_i = 1'b0, cpha_i = 1'b0, decode_i = 1'b0;
  logic [3:0]  cs_sel_i = '0;
  logic [31:0] delay_i = '0;
  logic        req_i = 1'b0;
  logic [3:0]  nbytes_i = '0;
  logic        sclk_o, shift_o, sample_o, done_o, idle_o;
  logic [3:0]  cs_n;

  int nchk = 0, nfail = 0, cyc = 0, last_rise = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sclk_cs_sequencer dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .enable_i(enable_i), .baud_i(baud_i),
    .cpol_i(cpol_i), .cpha_i(cpha_i), .decode_i(decode_i), .cs_sel_i(cs_sel_i),
    .delay_i(delay_i), .req_i(req_i), .nbytes_i(nbytes_i), .sclk_o(sclk_o),
    .cs_no(cs_n), .shift_o(shift_o), .sample_o(sample_o), .done_o(done_o),
    .idle_o(idle_o)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic cfg_set(input int baud, input bit cp, input bit ph, input bit dec,
                         input int sel, input int slch, input int chsh,
                         input int sd2d, input int shsl, input int nb);
    baud_i = 4'(baud); cpol_i = cp; cpha_i = ph; decode_i = dec;
    cs_sel_i = 4'(sel); nbytes_i = 4'(nb);
    delay_i = {8'(shsl), 8'(sd2d), 8'(chsh), 8'(slch)};
  endtask

  // Called at a negedge; issues a request and checks the whole transaction.
  task automatic txn(input int exp_gap, input bit mutate);
    int n, nb8, slch, chsh, f, edges, last_e, setup, nsh, nsa, bad_per, bad_str;
    int bad_pat, bad_done, guard;
    bit cp, ph, prev;
    logic [3:0] exp_pat;
    n = int'(baud_i); cp = cpol_i; ph = cpha_i;
    nb8 = 8 * (int'(nbytes_i) + 1);
    slch = int'(delay_i[7:0]); chsh = int'(delay_i[15:8]);
    exp_pat = decode_i ? cs_sel_i : (4'hF & ~(4'b0001 << cs_sel_i[1:0]));
    req_i = 1'b1;
    @(negedge clk);
    req_i = 1'b0;
    chk(idle_o == 1'b0, "R11 idle low after accept", int'(idle_o), 0);
    if (mutate) begin
      baud_i = baud_i ^ 4'h5; cs_sel_i = ~cs_sel_i; cpha_i = ~cpha_i;
      delay_i = delay_i ^ 32'h0303_0303; nbytes_i = nbytes_i + 4'd1;
    end
    guard = 0;
    while (cs_n == 4'hF && guard < 2000) begin @(negedge clk); guard++; end
    f = cyc;
    if (exp_gap >= 0) chk(f - last_rise == exp_gap, "R9/R10 select high time", f - last_rise, exp_gap);
    chk(cs_n == exp_pat, "R5/R6 select pattern", int'(cs_n), int'(exp_pat));
    chk(sclk_o == cp, "R2 sclk at select fall", int'(sclk_o), int'(cp));
    prev = sclk_o; edges = 0; last_e = f; setup = 0; nsh = 0; nsa = 0;
    bad_per = 0; bad_str = 0; bad_pat = 0; bad_done = 0; guard = 0;
    while (cs_n != 4'hF && guard < 5000) begin
      if (cs_n != exp_pat) bad_pat++;
      if (done_o) bad_done++;
      if (sclk_o != prev) begin
        edges++;
        if (edges == 1) setup = cyc - f;
        else if (cyc - last_e != n + 1) bad_per++;
        last_e = cyc; prev = sclk_o;
        if (sample_o) begin nsa++; if ((edges % 2 == 1) != !ph) bad_str++; end
        if (shift_o)  begin nsh++; if ((edges % 2 == 1) != ph)  bad_str++; end
      end else if (shift_o || sample_o) bad_str++;
      @(negedge clk); guard++;
    end
    last_rise = cyc;
    chk(done_o == 1'b1, "R11 done with select rise", int'(done_o), 1);
    chk(idle_o == 1'b1, "R11 idle at completion", int'(idle_o), 1);
    chk(sclk_o == cp, "R2 sclk rest after burst", int'(sclk_o), int'(cp));
    chk(setup == ((slch < 1) ? 1 : slch) + n + 1, "R7 setup to first edge", setup,
        ((slch < 1) ? 1 : slch) + n + 1);
    chk(cyc - last_e == ((chsh < 1) ? 1 : chsh), "R8 last edge to rise", cyc - last_e,
        (chsh < 1) ? 1 : chsh);
    chk(edges == 2 * nb8, "R4 edge count", edges, 2 * nb8);
    chk(bad_per == 0, "R1 half period", bad_per, 0);
    chk(nsa == nb8, "R3 sample count", nsa, nb8);
    chk(nsh == (ph ? nb8 : nb8 - 1), "R3 shift count", nsh, ph ? nb8 : nb8 - 1);
    chk(bad_str == 0, "R3 strobe placement", bad_str, 0);
    chk(bad_pat == 0, "R13 pattern held", bad_pat, 0);
    chk(bad_done == 0, "R11 no early done", bad_done, 0);
  endtask

  task automatic t_reset();
    chk(cs_n == 4'hF, "R12 reset select high", int'(cs_n), 15);
    chk(sclk_o == 1'b0, "R2 reset sclk", int'(sclk_o), 0);
    chk(done_o == 1'b0 && shift_o == 1'b0 && sample_o == 1'b0, "R11 reset strobes",
        int'({done_o, shift_o, sample_o}), 0);
    chk(idle_o == 1'b1, "R11 reset idle", int'(idle_o), 1);
  endtask

  task automatic t_basic();
    cfg_set(0, 0, 0, 0, 2, 3, 2, 10, 6, 0);
    repeat (3) @(negedge clk);
    txn(-1, 0);
  endtask

  task automatic t_pol_phase();
    // index 1 with upper bits set: upper bits must be ignored (R5)
    cfg_set(3, 1, 1, 0, 4'b0101, 0, 0, 0, 0, 1);
    repeat (3) @(negedge clk);
    chk(sclk_o == 1'b1, "R2 idle level follows polarity", int'(sclk_o), 1);
    txn(-1, 0);
  endtask

  task automatic t_decode();
    cfg_set(2, 1, 0, 1, 4'b1010, 1, 4, 0, 0, 0);
    repeat (3) @(negedge clk);
    txn(-1, 0);
  endtask

  task automatic t_gaps();
    cfg_set(1, 0, 0, 0, 1, 2, 2, 13, 7, 0);
    repeat (3) @(negedge clk);
    txn(-1, 0);
    txn(7, 0);          // R9 same device
    cs_sel_i = 4'd3;
    txn(13, 0);         // R10 device switch
    delay_i[31:24] = 8'd1;
    txn(2, 0);          // R9 floor
    cs_sel_i = 4'd0; delay_i[23:16] = 8'd0;
    txn(2, 0);          // R10 floor
  endtask

  task automatic t_enable();
    int bad;
    bad = 0;
    cfg_set(0, 0, 0, 0, 0, 1, 1, 0, 0, 0);
    enable_i = 1'b0;
    req_i = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (cs_n != 4'hF || idle_o != 1'b1) bad++;
    end
    req_i = 1'b0;
    chk(bad == 0, "R12 request ignored when disabled", bad, 0);
    enable_i = 1'b1;
    @(negedge clk);
    chk(cs_n == 4'hF, "R12 no late start", int'(cs_n), 15);
  endtask

  task automatic t_mutate();
    cfg_set(1, 0, 0, 0, 2, 2, 3, 0, 0, 1);
    repeat (3) @(negedge clk);
    txn(-1, 1);         // R13
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_pol_phase();
    t_decode();
    t_gaps();
    t_enable();
    t_mutate();
    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule